// File: doc/BRIEF.md
# Serial Command Receiver for a Multiplexed Fluorescent Display Controller

This block is the host-facing serial port of a multiplexed vacuum-fluorescent display controller. A host frames each command with a chip-select, clocks bits in on one data line, and ends every frame with a three-bit command code. The code is not known until the frame is over, so the block keeps a sliding window of the most recent bits. When chip-select drops, it decodes the code from the last three bits and moves the bits in front of it into the target register. Segment patterns go to one of three per-grid latches, or to all three at once. A ten-bit brightness duty goes to its own register. Three commands carry no payload: scan-stop, sleep, and a request to read back switch states.

A read has two steps. First a frame carrying the read code captures a parallel word of 30 switch states when chip-select falls. Then the next chip-select rise turns the data line around, and the block shifts the captured word out, one bit per serial clock rise. The block drives an output-enable so the pad can switch direction. Chip-select, serial clock and data are treated as synchronous to the system clock, and the block detects their edges against that clock.

Top module: `vfd_serial_cmd`

## Requirements
- R1: A bit is taken from `sdi` only on a rising edge of `sclk` while `cs` is high. `sclk` activity while `cs` is low adds nothing to the next frame.
- R2: The command code is taken from the last three bits received before `cs` falls, with weights 1, 2 and 4 for the third-last, second-last and last bit. A frame with fewer bits than its code needs (85 for codes 0-3, 13 for code 4, 3 for codes 5-7) changes no register. Bits beyond that length at the front of a frame are dropped.
- R3: Code 0 writes the 82-bit payload to all three grid latches. Codes 1, 2 and 3 write only the grid-1, grid-2 or grid-3 latch. Segment bit i (0-based) of a latch is the (i+1)-th payload bit sent.
- R4: Code 4 loads `dim_duty` from the ten payload bits, first bit sent as bit 0.
- R5: Grid latches, `dim_duty` and `sleep` change only in the cycle after `cs` falls, or for `sleep` also after `cs` rises.
- R6: Code 5 raises `scan_stop` for exactly one cycle.
- R7: Code 6 captures `key_in` when `cs` falls. At the next `cs` rise, `sdo_oe` goes high and `sdo` shows `key_in[0]`. Each `sclk` rise advances to the next bit. After 30 bits, `sdo` reads 0.
- R8: When `cs` falls, `sdo_oe` returns low, and the read frame writes no register.
- R9: Code 7 sets `sleep`. A `cs` rise clears it without any `scan_stop` pulse.
- R10: After reset, all latches and `dim_duty` are zero, and `sleep`, `scan_stop`, `sdo` and `sdo_oe` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Frame select, high during a frame |
| sclk | input | 1 | Serial bit clock |
| sdi | input | 1 | Serial data into the block |
| sdo | output | 1 | Serial data out during a read |
| sdo_oe | output | 1 | High while the block drives the data line |
| key_in | input | KEY_W | Parallel switch states to report |
| seg_g1 | output | SEG_W | Segment latch of grid 1 |
| seg_g2 | output | SEG_W | Segment latch of grid 2 |
| seg_g3 | output | SEG_W | Segment latch of grid 3 |
| dim_duty | output | DIM_W | Brightness duty value |
| scan_stop | output | 1 | One-cycle scan-stop request |
| sleep | output | 1 | Sleep state |

## Verification
The bench uses the defaults: 82 segment bits, 10 brightness bits and 30 switch bits. With these values, a full 85-bit frame fills the bit window exactly and the bit counter reaches saturation. A frame with leading extra bits and a frame cut short both stay within reach. The 30-bit readback runs past its end, so the zero fill after the last bit is exercised as well.

// File: rtl/vfd_serial_cmd.sv
module vfd_serial_cmd #(
  parameter int SEG_W = 82,
  parameter int DIM_W = 10,
  parameter int KEY_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             sclk,
  input  logic             sdi,
  output logic             sdo,
  output logic             sdo_oe,
  input  logic [KEY_W-1:0] key_in,
  output logic [SEG_W-1:0] seg_g1,
  output logic [SEG_W-1:0] seg_g2,
  output logic [SEG_W-1:0] seg_g3,
  output logic [DIM_W-1:0] dim_duty,
  output logic             scan_stop,
  output logic             sleep
);
  localparam int MODE_W  = 3;
  localparam int FRAME_W = SEG_W + MODE_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic cs_q, sclk_q;
  logic [FRAME_W-1:0] win;
  logic [CNT_W-1:0]   cnt;
  logic [KEY_W-1:0]   rd_sh;
  logic armed, rd_act;

  wire cs_rise   = cs & ~cs_q;
  wire cs_fall   = ~cs & cs_q;
  wire sclk_rise = sclk & ~sclk_q;
  wire take      = cs & sclk_rise & ~rd_act;
  wire commit    = cs_fall & ~rd_act;

  wire [2:0] mode   = {win[0], win[1], win[2]};
  wire       md_ok  = cnt >= CNT_W'(MODE_W);
  wire       dim_ok = cnt >= CNT_W'(DIM_W + MODE_W);
  wire       seg_ok = cnt == CNT_W'(FRAME_W);

  logic [SEG_W-1:0] seg_pay;
  logic [DIM_W-1:0] dim_pay;

  for (genvar i = 0; i < SEG_W; i++) begin : g_seg
    assign seg_pay[i] = win[FRAME_W-1-i];
  end
  for (genvar k = 0; k < DIM_W; k++) begin : g_dim
    assign dim_pay[k] = win[MODE_W+DIM_W-1-k];
  end

  assign sdo_oe = rd_act;
  assign sdo    = rd_act & rd_sh[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0;
      sclk_q <= 1'b0;
      win <= '0;
      cnt <= '0;
    end else begin
      cs_q <= cs;
      sclk_q <= sclk;
      if (cs_rise) cnt <= '0;
      else if (take) begin
        win <= {win[FRAME_W-2:0], sdi};
        if (cnt != CNT_W'(FRAME_W)) cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_g1 <= '0;
      seg_g2 <= '0;
      seg_g3 <= '0;
      dim_duty <= '0;
      scan_stop <= 1'b0;
    end else begin
      scan_stop <= commit & md_ok & (mode == 3'd5);
      if (commit && md_ok) begin
        case (mode)
          3'd0: if (seg_ok) begin
            seg_g1 <= seg_pay;
            seg_g2 <= seg_pay;
            seg_g3 <= seg_pay;
          end
          3'd1: if (seg_ok) seg_g1 <= seg_pay;
          3'd2: if (seg_ok) seg_g2 <= seg_pay;
          3'd3: if (seg_ok) seg_g3 <= seg_pay;
          3'd4: if (dim_ok) dim_duty <= dim_pay;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep <= 1'b0;
      armed <= 1'b0;
      rd_act <= 1'b0;
      rd_sh <= '0;
    end else begin
      if (cs_rise) sleep <= 1'b0;
      else if (commit && md_ok && mode == 3'd7) sleep <= 1'b1;

      if (commit) begin
        armed <= md_ok & (mode == 3'd6);
        if (md_ok && mode == 3'd6) rd_sh <= key_in;
      end else if (cs_rise && armed) begin
        armed <= 1'b0;
        rd_act <= 1'b1;
      end

      if (cs_fall && rd_act) rd_act <= 1'b0;
      else if (rd_act && cs && sclk_rise) rd_sh <= rd_sh >> 1;
    end
  end

  // R8
  pin_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_fall |=> !sdo_oe);

  // R5
  hold_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_fall |=> $stable(seg_g1) && $stable(seg_g2) && $stable(seg_g3) && $stable(dim_duty));

  // R6
  stop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_stop |=> !scan_stop);

  // R9
  wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !sleep);

  // R7
  drive_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> cs_q);

  // R9
  wake_no_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise |=> !scan_stop);
endmodule

// File: tb/vfd_serial_cmd_bench.sv
module vfd_serial_cmd_bench;
  localparam int SEG_W = 82, DIM_W = 10, KEY_W = 30;

  logic clk = 0, rst_n = 0, cs = 0, sclk = 0, sdi = 0;
  logic [KEY_W-1:0] key_in = '0;
  logic sdo, sdo_oe, scan_stop, sleep;
  logic [SEG_W-1:0] seg_g1, seg_g2, seg_g3;
  logic [DIM_W-1:0] dim_duty;

  int checks = 0, errors = 0, stop_seen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vfd_serial_cmd #(.SEG_W(SEG_W), .DIM_W(DIM_W), .KEY_W(KEY_W)) u_vfd_serial_cmd (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .sdo_oe(sdo_oe), .key_in(key_in), .seg_g1(seg_g1), .seg_g2(seg_g2),
    .seg_g3(seg_g3), .dim_duty(dim_duty), .scan_stop(scan_stop), .sleep(sleep));

  // behavioural reference
  bit q[$];
  logic [SEG_W-1:0] m_seg [3];
  logic [DIM_W-1:0] m_dim;
  logic [KEY_W-1:0] m_cap;
  logic m_stop, m_sleep, m_armed, m_rd, p_cs, p_sclk;
  int rd_idx;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < 3; g++) m_seg[g] = '0;
      m_dim = '0; m_cap = '0; m_stop = 0; m_sleep = 0; m_armed = 0; m_rd = 0;
      p_cs = 0; p_sclk = 0; rd_idx = 0; q.delete();
    end else begin
      m_stop = 0;
      if (cs && !p_cs) begin
        q.delete();
        m_sleep = 0;
        if (m_armed) begin m_armed = 0; m_rd = 1; rd_idx = 0; end
      end else if (cs && sclk && !p_sclk) begin
        if (m_rd) rd_idx++;
        else q.push_back(sdi);
      end
      if (!cs && p_cs) begin
        if (m_rd) m_rd = 0;
        else begin
          int n, md, need;
          n = q.size();
          m_armed = 0;
          if (n >= 3) begin
            md = q[n-3] + 2*q[n-2] + 4*q[n-1];
            need = (md < 4) ? SEG_W : (md == 4) ? DIM_W : 0;
            if (n - 3 >= need) begin
              if (md < 4) begin
                for (int i = 0; i < SEG_W; i++) begin
                  if (md == 0 || md == 1) m_seg[0][i] = q[n-3-SEG_W+i];
                  if (md == 0 || md == 2) m_seg[1][i] = q[n-3-SEG_W+i];
                  if (md == 0 || md == 3) m_seg[2][i] = q[n-3-SEG_W+i];
                end
              end else if (md == 4) begin
                for (int k = 0; k < DIM_W; k++) m_dim[k] = q[n-3-DIM_W+k];
              end else if (md == 5) m_stop = 1;
              else if (md == 6) begin m_cap = key_in; m_armed = 1; end
              else m_sleep = 1;
            end
          end
        end
      end
      p_cs = cs; p_sclk = sclk;
    end
  end

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R3 seg_g1", seg_g1, m_seg[0]);
    chk("R3 seg_g2", seg_g2, m_seg[1]);
    chk("R3 seg_g3", seg_g3, m_seg[2]);
    chk("R4 dim_duty", dim_duty, m_dim);
    chk("R6 scan_stop", scan_stop, m_stop);
    chk("R9 sleep", sleep, m_sleep);
    chk("R8 sdo_oe", sdo_oe, m_rd);
    chk("R7 sdo", sdo, (m_rd && rd_idx < KEY_W) ? m_cap[rd_idx] : 1'b0);
    if (scan_stop) stop_seen++;
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic bit_out(logic b);
    sdi = b; wait_n(1); sclk = 1; wait_n(1); sclk = 0;
  endtask
  task automatic cs_hi(); cs = 1; wait_n(2); endtask
  task automatic cs_lo(); cs = 0; wait_n(2); endtask
  task automatic send_cmd(int junk, int npay, logic [SEG_W-1:0] pay, int md);
    cs_hi();
    for (int j = 0; j < junk; j++) bit_out(j[0]);
    for (int i = 0; i < npay; i++) bit_out(pay[i]);
    for (int b = 0; b < 3; b++) bit_out(md[b]);
    cs_lo();
  endtask

  localparam logic [SEG_W-1:0] PA = 82'h2_5A5A_1234_89AB_CDEF_0F0F;
  localparam logic [SEG_W-1:0] PB = 82'h1_FFFF_0000_1357_9BDF_C3C3;
  localparam logic [SEG_W-1:0] PC = 82'h3_0F1E_2D3C_4B5A_6978_8796;

  initial begin
    wait_n(3);
    // R10
    chk("R10 seg_g1", seg_g1, 0); chk("R10 dim", dim_duty, 0);
    chk("R10 sdo_oe", sdo_oe, 0); chk("R10 sleep", sleep, 0);
    chk("R10 scan_stop", scan_stop, 0); chk("R10 sdo", sdo, 0);
    rst_n = 1; wait_n(2);

    send_cmd(0, SEG_W, PA, 0);
    chk("R3 all grids g1", seg_g1, PA); chk("R3 all grids g3", seg_g3, PA);
    send_cmd(0, SEG_W, PB, 2);
    chk("R3 only g2", seg_g2, PB); chk("R3 g1 kept", seg_g1, PA);
    send_cmd(0, DIM_W, 82'h2A5, 4);
    chk("R4 dim lsb first", dim_duty, 10'h2A5);

    send_cmd(0, 40, PC, 1);
    chk("R2 short frame discarded", seg_g1, PA);
    send_cmd(0, 5, 82'h1F, 4);
    chk("R2 short dim discarded", dim_duty, 10'h2A5);
    send_cmd(5, SEG_W, PC, 1);
    chk("R2 leading extra bits dropped", seg_g1, PC);

    for (int i = 0; i < 6; i++) bit_out(1'b1);
    send_cmd(0, SEG_W, PB, 3);
    chk("R1 cs low clocks ignored", seg_g3, PB);

    // R5: mid-frame, nothing changes yet
    cs_hi();
    for (int i = 0; i < DIM_W; i++) bit_out(i[0]);
    for (int b = 0; b < 3; b++) bit_out(b == 2);
    chk("R5 dim held before cs fall", dim_duty, 10'h2A5);
    cs_lo();
    chk("R5 dim after cs fall", dim_duty, 10'h2AA);

    stop_seen = 0;
    send_cmd(0, 0, '0, 5);
    wait_n(2);
    chk("R6 one stop pulse", stop_seen, 1);

    key_in = 30'h2BCD_1357;
    send_cmd(0, 0, '0, 6);
    key_in = 30'h0000_0FFF;
    chk("R8 no drive before turnaround", sdo_oe, 0);
    cs_hi();
    chk("R7 drive after cs rise", sdo_oe, 1);
    begin
      logic [KEY_W-1:0] got;
      for (int i = 0; i < KEY_W; i++) begin got[i] = sdo; bit_out(1'b0); end
      chk("R7 readback word", got, 30'h2BCD_1357);
      chk("R7 zero after last bit", sdo, 0);
    end
    cs_lo();
    chk("R8 released", sdo_oe, 0);
    chk("R8 read writes nothing", seg_g1, PC);

    stop_seen = 0;
    send_cmd(0, 0, '0, 7);
    chk("R9 sleep set", sleep, 1);
    cs_hi();
    chk("R9 woken", sleep, 0);
    chk("R9 no stop on wake", stop_seen, 0);
    cs_lo();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule